// File: doc/BRIEF.md
# Programmable Fill-Level Flag Generator with Selectable Timing

This block produces the two active-low threshold flags of a dual-clock FIFO: an almost-full flag and an almost-empty flag. It keeps its own write and read pointers, which advance on one-cycle increment strobes in their own clock domains. Each pointer is passed to the other domain in Gray code through a two-flop synchronizer. Each side then has its own view of the fill level, which it compares with two offsets: one for the full side and one for the empty side. The memory itself and the loading of the offsets are done elsewhere. The offsets are treated as quasi-static.

A timing strap, sampled while reset is held, chooses how the flags move. In local timing each flag is a register of one clock. Almost-full belongs to the write clock and almost-empty to the read clock. In split timing each flag is asserted by one clock and released by the other. Almost-full is asserted on a write-clock edge and released on a read-clock edge. Almost-empty is asserted on a read-clock edge and released on a write-clock edge. Split timing is built from a toggle pair: the assert side flips its bit, and the release side flips the other bit.

Top module: `prog_level_flags`

## Requirements
- R1: While reset is held, and on leaving reset, the almost-full output is 1 (inactive) and the almost-empty output is 0 (active), in either timing mode.
- R2: The timing strap is sampled only while reset is high. A value of 1 selects local timing and 0 selects split timing. A change of the strap after reset has no effect until the next reset.
- R3: Once both domains have settled, the almost-empty output is 0 when the number of stored words is at most the empty offset, and 1 otherwise.
- R4: Once both domains have settled, the almost-full output is 0 when the free space (DEPTH minus the stored words) is at most the full offset, and 1 otherwise.
- R5: In local timing, the almost-full output changes only at rising edges of the write clock.
- R6: In local timing, the almost-empty output changes only at rising edges of the read clock.
- R7: In split timing, the almost-full output falls only at write-clock rising edges and rises only at read-clock rising edges.
- R8: In split timing, the almost-empty output falls only at read-clock rising edges and rises only at write-clock rising edges.
- R9: The offset extremes behave as stated. An empty offset of 0 flags only a fully empty FIFO. A full offset of 0 flags only a completely full FIFO, with DEPTH words stored.
- R10: The flags stay correct after both pointers have wrapped several times. Each pointer's Gray code changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| timing_strap | input | 1 | Timing select sampled during reset: 1 local, 0 split |
| wr_inc | input | 1 | Write pointer advance strobe (wclk domain) |
| rd_inc | input | 1 | Read pointer advance strobe (rclk domain) |
| full_off | input | $clog2(DEPTH) | Almost-full offset, 0 to DEPTH-1 |
| empty_off | input | $clog2(DEPTH) | Almost-empty offset, 0 to DEPTH-1 |
| paf_n | output | 1 | Almost-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench records the time of every write-clock and read-clock edge. The two clocks never share an edge. Each flag transition is therefore attributed to a clock, and a swapped set or clear domain is reported as a transition on the wrong clock. Fill levels are checked exactly at each offset and one word beyond it. An off-by-one compare would move the flag one word early or late. The zero-offset and wrapped-pointer runs catch an unsigned subtraction that loses a bit. The strap is changed after reset to catch a design that follows the live strap instead of the latched one.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [0:0] {
    TM_SPLIT = 1'b0,
    TM_LOCAL = 1'b1
  } timing_e;
endpackage

// File: rtl/lf_sync2.sv
module lf_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lf_gray_ptr.sv
module lf_gray_ptr #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] gray
);
  logic [PW-1:0] bin_nx;

  assign bin_nx = bin + PW'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_nx;
      gray <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/lf_flag.sv
module lf_flag
  import lf_pkg::*;
#(
  parameter bit RST_ASSERTED = 1'b0
) (
  input  logic    rst,
  input  logic    a_clk,
  input  timing_e a_mode,
  input  logic    a_cond,
  input  logic    b_clk,
  input  logic    b_clr,
  output logic    flag_n
);
  logic local_q;
  logic s_tog;
  logic c_tog;
  logic c_in_a;
  logic s_in_b;
  logic on_a;
  logic on_b;

  lf_sync2 #(.W(1)) u_c2a (.clk(a_clk), .rst(rst), .d(c_tog), .q(c_in_a));
  lf_sync2 #(.W(1)) u_s2b (.clk(b_clk), .rst(rst), .d(s_tog), .q(s_in_b));

  assign on_a = s_tog ^ c_in_a ^ RST_ASSERTED;
  assign on_b = s_in_b ^ c_tog ^ RST_ASSERTED;

  always_ff @(posedge a_clk) begin
    if (rst) begin
      local_q <= ~RST_ASSERTED;
      s_tog   <= 1'b0;
    end else begin
      local_q <= ~a_cond;
      if (!on_a && a_cond) s_tog <= ~s_tog;
    end
  end

  always_ff @(posedge b_clk) begin
    if (rst) c_tog <= 1'b0;
    else if (on_b && b_clr) c_tog <= ~c_tog;
  end

  assign flag_n = (a_mode == TM_LOCAL) ? local_q : ~(s_tog ^ c_tog ^ RST_ASSERTED);
endmodule

// File: rtl/prog_level_flags.sv
module prog_level_flags
  import lf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int OW = $clog2(DEPTH),
  localparam int PW = OW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          timing_strap,
  input  logic          wr_inc,
  input  logic          rd_inc,
  input  logic [OW-1:0] full_off,
  input  logic [OW-1:0] empty_off,
  output logic          paf_n,
  output logic          pae_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] wfill, wfree, rfill, rfree;
  logic [PW-1:0] foff_x, eoff_x;
  timing_e       mode_w, mode_r;

  always_ff @(posedge wclk) if (rst) mode_w <= timing_e'(timing_strap);
  always_ff @(posedge rclk) if (rst) mode_r <= timing_e'(timing_strap);

  lf_gray_ptr #(.PW(PW)) u_wptr (.clk(wclk), .rst(rst), .step(wr_inc), .bin(wbin), .gray(wgray));
  lf_gray_ptr #(.PW(PW)) u_rptr (.clk(rclk), .rst(rst), .step(rd_inc), .bin(rbin), .gray(rgray));

  lf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_w));
  lf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_r));

  assign foff_x = {1'b0, full_off};
  assign eoff_x = {1'b0, empty_off};
  assign wfill  = wbin - g2b(rgray_w);
  assign wfree  = DEPTH_P - wfill;
  assign rfill  = g2b(wgray_r) - rbin;
  assign rfree  = DEPTH_P - rfill;

  lf_flag #(.RST_ASSERTED(1'b0)) u_paf (
    .rst(rst),
    .a_clk(wclk), .a_mode(mode_w), .a_cond(wfree <= foff_x),
    .b_clk(rclk), .b_clr(rfree > foff_x),
    .flag_n(paf_n)
  );

  lf_flag #(.RST_ASSERTED(1'b1)) u_pae (
    .rst(rst),
    .a_clk(rclk), .a_mode(mode_r), .a_cond(rfill <= eoff_x),
    .b_clk(wclk), .b_clr(wfill > eoff_x),
    .flag_n(pae_n)
  );
endmodule

// File: rtl/lf_checker.sv
module lf_checker
  import lf_pkg::*;
#(
  parameter int OW = 4,
  parameter int PW = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          paf_n,
  input logic          pae_n,
  input logic [OW-1:0] full_off,
  input logic [OW-1:0] empty_off,
  input timing_e       mode_w,
  input timing_e       mode_r,
  input logic [PW-1:0] wfree,
  input logic [PW-1:0] rfill,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  assert_reset_paf_R1: assert property (@(posedge wclk) disable iff (rst)
    $fell(rst) |-> paf_n);

  assert_reset_pae_R1: assert property (@(posedge rclk) disable iff (rst)
    $fell(rst) |-> !pae_n);

  assert_paf_release_R4: assert property (@(posedge wclk) disable iff (rst)
    (mode_w == TM_LOCAL && wfree > {1'b0, full_off} && $stable(wfree)) |=> paf_n);

  assert_pae_release_R3: assert property (@(posedge rclk) disable iff (rst)
    (mode_r == TM_LOCAL && rfill > {1'b0, empty_off} && $stable(rfill)) |=> pae_n);

  assert_wgray_step_R10: assert property (@(posedge wclk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));

  assert_rgray_step_R10: assert property (@(posedge rclk) disable iff (rst)
    $onehot0(rgray ^ $past(rgray)));
endmodule

bind prog_level_flags lf_checker #(.OW(OW), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .paf_n(paf_n), .pae_n(pae_n),
  .full_off(full_off), .empty_off(empty_off), .mode_w(mode_w), .mode_r(mode_r),
  .wfree(wfree), .rfill(rfill), .wgray(wgray), .rgray(rgray)
);

// File: tb/tb_prog_level_flags.sv
`timescale 1ns/1ps
module tb_prog_level_flags;
  localparam int DEPTH = 16;
  localparam int OW = $clog2(DEPTH);

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1, strap = 1'b1;
  logic wr_inc = 1'b0, rd_inc = 1'b0;
  logic [OW-1:0] full_off = '0, empty_off = '0;
  logic paf_n, pae_n;

  int n_chk = 0, n_bad = 0;
  bit mon_en = 1'b0;
  bit exp_local = 1'b1;
  int fill = 0;
  int seen_paf_f = 0, seen_paf_r = 0, seen_pae_f = 0, seen_pae_r = 0;
  time last_w = 0, last_r = 0;

  always #10 wclk = ~wclk;
  initial begin #7; forever begin rclk = ~rclk; #14; end end

  always @(posedge wclk) last_w = $time;
  always @(posedge rclk) last_r = $time;

  prog_level_flags #(.DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .rst(rst), .timing_strap(strap),
    .wr_inc(wr_inc), .rd_inc(rd_inc), .full_off(full_off), .empty_off(empty_off),
    .paf_n(paf_n), .pae_n(pae_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // edge attribution: 'W' write clock, 'R' read clock, '?' neither
  function automatic int which_clk(input time t);
    if (last_w == t) return 87;
    if (last_r == t) return 82;
    return 63;
  endfunction

  always @(paf_n) begin : mon_paf
    time t;
    logic v;
    int c, e;
    t = $time; v = paf_n;
    #1;
    if (mon_en && (v === 1'b0 || v === 1'b1)) begin
      c = which_clk(t);
      if (v === 1'b0) begin e = 87; seen_paf_f++; end
      else begin e = exp_local ? 87 : 82; seen_paf_r++; end
      check(c == e, exp_local ? "R5 paf edge clock" : "R7 paf edge clock", c, e);
    end
  end

  always @(pae_n) begin : mon_pae
    time t;
    logic v;
    int c, e;
    t = $time; v = pae_n;
    #1;
    if (mon_en && (v === 1'b0 || v === 1'b1)) begin
      c = which_clk(t);
      if (v === 1'b0) begin e = 82; seen_pae_f++; end
      else begin e = exp_local ? 82 : 87; seen_pae_r++; end
      check(c == e, exp_local ? "R6 pae edge clock" : "R8 pae edge clock", c, e);
    end
  end

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    #3;
  endtask

  task automatic do_reset(input bit local_mode, input int n, input int m);
    mon_en = 1'b0;
    @(negedge wclk);
    rst = 1'b1; strap = local_mode; exp_local = local_mode;
    empty_off = OW'(n); full_off = OW'(m);
    fill = 0;
    repeat (6) @(posedge rclk);
    @(negedge wclk);
    check(paf_n === 1'b1, "R1 paf during reset", int'(paf_n), 1);
    check(pae_n === 1'b0, "R1 pae during reset", int'(pae_n), 0);
    rst = 1'b0;
    settle();
    check(paf_n === 1'b1, "R1 paf after reset", int'(paf_n), 1);
    check(pae_n === 1'b0, "R1 pae after reset", int'(pae_n), 0);
    seen_paf_f = 0; seen_paf_r = 0; seen_pae_f = 0; seen_pae_r = 0;
    mon_en = 1'b1;
  endtask

  task automatic write_words(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge wclk); wr_inc = 1'b1;
    end
    @(negedge wclk); wr_inc = 1'b0;
    fill += k;
    settle();
  endtask

  task automatic read_words(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge rclk); rd_inc = 1'b1;
    end
    @(negedge rclk); rd_inc = 1'b0;
    fill -= k;
    settle();
  endtask

  task automatic check_levels(input string tag);
    int ea, ef;
    ea = (fill <= int'(empty_off)) ? 0 : 1;
    ef = ((DEPTH - fill) <= int'(full_off)) ? 0 : 1;
    check(pae_n === ea[0], {tag, " R3 pae level"}, int'(pae_n), ea);
    check(paf_n === ef[0], {tag, " R4 paf level"}, int'(paf_n), ef);
  endtask

  task automatic check_seen(input string tag);
    check(seen_paf_f > 0, {tag, " paf fall seen"}, seen_paf_f, 1);
    check(seen_paf_r > 0, {tag, " paf rise seen"}, seen_paf_r, 1);
    check(seen_pae_f > 0, {tag, " pae fall seen"}, seen_pae_f, 1);
    check(seen_pae_r > 0, {tag, " pae rise seen"}, seen_pae_r, 1);
  endtask

  task automatic test_local_timing();
    do_reset(1'b1, 3, 2);
    write_words(3);  check_levels("local n");
    write_words(1);  check_levels("local n+1");
    write_words(9);  check_levels("local free m+1");
    write_words(1);  check_levels("local free m");
    read_words(1);   check_levels("local after read");
    read_words(10);  check_levels("local back to n");
    check_seen("R5 R6 local");
  endtask

  task automatic test_split_timing();
    do_reset(1'b0, 3, 2);
    strap = 1'b1;  // R2: strap change after reset must not switch mode
    write_words(4);  check_levels("split n+1");
    write_words(10); check_levels("split free m");
    read_words(1);   check_levels("split free m+1");
    read_words(10);  check_levels("split n");
    check_seen("R7 R8 R2 split");
  endtask

  task automatic test_extremes();
    do_reset(1'b1, 0, 0);
    write_words(1);  check_levels("R9 one word");
    read_words(1);   check_levels("R9 empty");
    write_words(15); check_levels("R9 fifteen");
    write_words(1);  check_levels("R9 full");
    read_words(1);   check_levels("R9 one free");
    read_words(15);
  endtask

  task automatic test_wrap();
    do_reset(1'b1, 5, 5);
    for (int i = 0; i < 5; i++) begin
      write_words(11); check_levels("R10 wrap high");
      write_words(1);  check_levels("R10 wrap free m-1");
      read_words(7);   check_levels("R10 wrap n");
      read_words(5);
    end
    write_words(6);  check_levels("R10 wrap n+1");
  endtask

  initial begin : watchdog
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    test_local_timing();
    test_split_timing();
    test_extremes();
    test_wrap();
    mon_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule